// File: doc/BRIEF.md
# Shared Farrow Fractional-Delay Skew Corrector

This block removes sampling-time skew from the merged output stream of a four-way time-interleaved converter. It uses one fractional-delay filter on the full-rate stream, shared by every lane. Each incoming sample carries the index of the lane that produced it. The block looks up that lane's skew, alpha, and delays the stream by two samples plus alpha. Lane 0 is the timing reference and always uses alpha = 0.

The filter is a fifth-order Lagrange interpolator in Farrow form. Six fixed sub-filters each produce one coefficient of a polynomial in alpha. A pipelined Horner chain then evaluates that polynomial, with one multiply-add per stage. The sub-filter coefficients are constants, worked out from the Lagrange product when the design is elaborated. A skew estimator elsewhere supplies the alpha values.

Top module: `farrow_skew_corrector`

## Requirements
- R1: While reset is asserted, and after it is released with no input, `out_valid`, `out_chan` and `out_sample` are all zero.
- R2: Each input sample with `in_valid` high produces exactly one output with `out_valid` high, 8 clock edges later (order + 3), in input order. The output's `out_chan` equals the sample's `in_chan`.
- R3: For a lane-0 sample, `out_sample` equals the accepted sample from two valid inputs earlier, multiplied by 4, with no error. The output has 2 fractional guard bits, so one output LSB is a quarter of an input LSB.
- R4: For lanes 1 to 3, `out_sample` equals 4 times the order-5 Lagrange interpolation of the accepted input stream at delay 2 + alpha, to within 4 output LSBs. The interpolation uses the newest six accepted samples. Alpha is signed Q1.15 with magnitude below 1. Lane 1 takes `skew_in[15:0]`, lane 2 takes `skew_in[31:16]` and lane 3 takes `skew_in[47:32]`.
- R5: The delay switches sample by sample. Each output uses the alpha of its own lane, even when lanes interleave and their alphas differ widely.
- R6: Cycles with `in_valid` low leave the filter history unchanged. `in_sample` and `in_chan` are ignored in those cycles, so gaps do not change any later output.
- R7: Results beyond the output range saturate to 8191 and -8192.
- R8: When no output is produced, `out_sample` and `out_chan` hold their previous values and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_chan | input | 2 | Lane that produced the input sample |
| in_sample | input | 12 | Signed input sample |
| skew_in | input | 48 | Q1.15 skews of lanes 1, 2 and 3, lane 1 in the low bits |
| out_valid | output | 1 | Corrected sample present |
| out_chan | output | 2 | Lane tag of the corrected sample |
| out_sample | output | 14 | Signed corrected sample with 2 fractional bits |

## Verification
The assertions assume that every alpha selected on a valid cycle stays strictly inside ±1. That means the Q1.15 code 0x8000 never reaches the filter while it is in use. The stimulus keeps every skew between -0.75 and +0.9. The bench's reference model uses the same delay convention, and it advances its history only on valid cycles. In gap cycles the bench drives invalid data and lane codes that the design must ignore. Saturation is reached only through sample patterns whose signs follow the interpolation weights at alpha = 0.5; the skew range is never stretched to get there.

// File: rtl/farrow_skew_corrector.sv
`timescale 1ns/1ps
module farrow_skew_corrector #(
  parameter int W   = 12,
  parameter int NCH = 4,
  parameter int ORD = 5,
  parameter int CW  = 18,
  parameter int AW  = 16,
  parameter int G   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [$clog2(NCH)-1:0]        in_chan,
  input  logic signed [W-1:0]           in_sample,
  input  logic [(NCH-1)*AW-1:0]         skew_in,
  output logic                          out_valid,
  output logic [$clog2(NCH)-1:0]        out_chan,
  output logic signed [W+G-1:0]         out_sample
);
  localparam int NT    = ORD + 1;
  localparam int CHW   = $clog2(NCH);
  localparam int CF    = CW - 2;
  localparam int AF    = AW - 1;
  localparam int D0    = ORD / 2;
  localparam int ACCW  = W + CW + $clog2(NT) + 4;
  localparam int PW    = ACCW + AW;
  localparam int OW    = W + G;
  localparam int SH    = CF - G;
  localparam int HALFA = 1 << (AF - 1);
  localparam int RHALF = 1 << (SH - 1);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 << (OW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;

  function automatic logic signed [CW-1:0] lag_coef(input int k, input int j);
    longint p [NT];
    longint den, num, q;
    for (int i = 0; i < NT; i++) p[i] = 0;
    p[0] = 1;
    den  = 1;
    for (int l = 0; l < NT; l++) begin
      if (l != k) begin
        for (int i = NT - 1; i > 0; i--) p[i] = p[i-1] + p[i] * longint'(D0 - l);
        p[0] = p[0] * longint'(D0 - l);
        den  = den * longint'(k - l);
      end
    end
    num = p[j] <<< CF;
    q = ((num < 0) == (den < 0)) ? (2 * num + den) / (2 * den) : (2 * num - den) / (2 * den);
    return CW'(q);
  endfunction

  logic signed [CW-1:0]   coef [NT][NT];
  logic signed [W-1:0]    tap [NT];
  logic [NCH*AW-1:0]      skew_all;
  logic signed [AW-1:0]   alpha_a;
  logic [CHW-1:0]         chan_a;
  logic                   vld_a;
  logic signed [ACCW-1:0] vsum [NT];
  logic signed [ACCW-1:0] hv [ORD+1][NT];
  logic signed [ACCW-1:0] hacc [ORD+1];
  logic signed [AW-1:0]   ha [ORD+1];
  logic [CHW-1:0]         hch [ORD+1];
  logic                   hvld [ORD+1];
  logic signed [PW-1:0]   prod [ORD];
  logic signed [PW-1:0]   scaled [ORD];
  logic signed [ACCW-1:0] rsum, rnd;
  logic signed [OW-1:0]   satv;

  for (genvar gk = 0; gk < NT; gk++) begin : g_ck
    for (genvar gj = 0; gj < NT; gj++) begin : g_cj
      assign coef[gk][gj] = lag_coef(gk, gj);
    end
  end

  assign skew_all = {skew_in, AW'(0)};

  always_comb begin
    for (int j = 0; j < NT; j++) begin
      vsum[j] = '0;
      for (int k = 0; k < NT; k++)
        vsum[j] = vsum[j] + ACCW'(coef[k][j]) * ACCW'(tap[k]);
    end
  end

  always_comb begin
    for (int s = 0; s < ORD; s++) begin
      prod[s]   = PW'(hacc[s]) * PW'(ha[s]);
      scaled[s] = (prod[s] + PW'(HALFA)) >>> AF;
    end
  end

  assign rsum = hacc[ORD] + ACCW'(RHALF);
  assign rnd  = rsum >>> SH;
  assign satv = (rnd > MAXV) ? OW'(MAXV) : (rnd < MINV) ? OW'(MINV) : OW'(rnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) tap[k] <= '0;
      alpha_a <= '0;
      chan_a  <= '0;
      vld_a   <= 1'b0;
      for (int s = 0; s <= ORD; s++) begin
        hacc[s] <= '0;
        ha[s]   <= '0;
        hch[s]  <= '0;
        hvld[s] <= 1'b0;
        for (int j = 0; j < NT; j++) hv[s][j] <= '0;
      end
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
    end else begin
      vld_a <= in_valid;
      if (in_valid) begin
        tap[0] <= in_sample;
        for (int k = 1; k < NT; k++) tap[k] <= tap[k-1];
        alpha_a <= skew_all[int'(in_chan)*AW +: AW];
        chan_a  <= in_chan;
      end
      hacc[0] <= vsum[ORD];
      for (int j = 0; j < NT; j++) hv[0][j] <= vsum[j];
      ha[0]   <= alpha_a;
      hch[0]  <= chan_a;
      hvld[0] <= vld_a;
      for (int s = 1; s <= ORD; s++) begin
        hacc[s] <= $signed(scaled[s-1][ACCW-1:0]) + hv[s-1][ORD-s];
        for (int j = 0; j < NT; j++) hv[s][j] <= hv[s-1][j];
        ha[s]   <= ha[s-1];
        hch[s]  <= hch[s-1];
        hvld[s] <= hvld[s-1];
      end
      out_valid <= hvld[ORD];
      if (hvld[ORD]) begin
        out_chan   <= hch[ORD];
        out_sample <= satv;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
  AST_REF_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vld_a && (chan_a == '0) |-> (alpha_a == '0)); // R3
  AST_SKEW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (skew_all[int'(in_chan)*AW +: AW] != {1'b1, {(AW-1){1'b0}}})); // R4
  AST_GAP_KEEPS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tap[0]) && $stable(tap[ORD])); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(rnd) > MAXV) |-> (out_sample == OW'(MAXV))); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(rnd) < MINV) |-> (out_sample == OW'(MINV))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hvld[ORD] |=> $stable(out_sample) && $stable(out_chan) && !out_valid); // R8
endmodule

// File: tb/farrow_skew_corrector_bench.sv
`timescale 1ns/1ps
module farrow_skew_corrector_bench;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_chan = '0;
  logic signed [11:0] in_sample = '0;
  logic signed [15:0] sk [1:3];
  logic [47:0] skew_in;
  logic out_valid;
  logic [1:0] out_chan;
  logic signed [13:0] out_sample;

  int checks = 0, fails = 0, cyc = 0;
  int hist [6];
  int e_val [0:4095];
  int e_ch [0:4095];
  int e_cyc [0:4095];
  int e_tol [0:4095];
  string e_tag [0:4095];
  int wp = 0, rp = 0;

  assign skew_in = {sk[3], sk[2], sk[1]};

  farrow_skew_corrector u_farrow_skew_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .skew_in(skew_in), .out_valid(out_valid),
    .out_chan(out_chan), .out_sample(out_sample));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic real lagw(input int k, input real d);
    real r = 1.0;
    for (int l = 0; l < 6; l++) if (l != k) r = r * (d - l) / (k - l);
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rp >= wp) chk(1'b0, "R2 unexpected output", int'(out_sample), 0);
      else begin
        chk((int'(out_sample) - e_val[rp] <= e_tol[rp]) && (e_val[rp] - int'(out_sample) <= e_tol[rp]),
            e_tag[rp], int'(out_sample), e_val[rp]);
        chk(int'(out_chan) == e_ch[rp], "R2 lane tag", int'(out_chan), e_ch[rp]);
        chk(cyc - e_cyc[rp] == LAT, "R2 latency", cyc - e_cyc[rp], LAT);
        rp++;
      end
    end
  end

  task automatic push(input int x, input int ch, input string tag);
    real a, y;
    int q;
    @(negedge clk);
    in_valid  = 1'b1;
    in_chan   = 2'(ch);
    in_sample = 12'(x);
    for (int k = 5; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    a = (ch == 0) ? 0.0 : real'(sk[ch]) / 32768.0;
    y = 0.0;
    for (int k = 0; k < 6; k++) y = y + lagw(k, 2.0 + a) * hist[k];
    q = $rtoi($floor(y * 4.0 + 0.5));
    if (q > 8191) q = 8191;
    if (q < -8192) q = -8192;
    e_val[wp] = q;
    e_ch[wp]  = ch;
    e_cyc[wp] = cyc;
    e_tol[wp] = (ch == 0) ? 0 : 4;
    e_tag[wp] = (ch == 0) ? "R3 lane-0 output" : tag;
    wp++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 12'(1234 - 97 * i);
      in_chan   = 2'(i + 1);
    end
  endtask

  task automatic drain();
    idle(LAT + 4);
    chk(rp == wp, "R2 output count", rp, wp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(out_sample == '0, "R1 sample after reset", int'(out_sample), 0);
    chk(out_chan == '0, "R1 lane after reset", int'(out_chan), 0);
  endtask

  task automatic t_reference_lane();
    for (int i = 0; i < 24; i++) push((i * 389) % 4000 - 2000, 0, "R3 pass");
    drain();
  endtask

  task automatic t_ramp();
    sk[1] = -16'sd655; sk[2] = 16'sd328; sk[3] = -16'sd492;
    for (int i = 0; i < 60; i++) push(-1500 + 17 * i, i % 4, "R4 ramp interpolation");
    drain();
  endtask

  task automatic t_switch();
    sk[1] = 16'sd29491; sk[2] = -16'sd24576; sk[3] = 16'sd16384;
    for (int i = 0; i < 48; i++) push($rtoi(1800.0 * $sin(0.7 * i)), i % 4, "R5 per-lane alpha");
    for (int i = 0; i < 24; i++) push($rtoi(1500.0 * $sin(1.9 * i)), 3 - (i % 4), "R5 reversed lanes");
    drain();
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 30; i++) begin
      push($rtoi(1700.0 * $sin(0.45 * i)), (i * 3) % 4, "R6 gaps ignored");
      idle(i % 3);
    end
    drain();
  endtask

  task automatic t_saturate();
    int pat [6] = '{1, -1, 1, 1, -1, 1};
    sk[1] = 16'sd16384;
    for (int i = 0; i < 6; i++) push(2047 * pat[i], (i == 5) ? 1 : 0, "R7 positive clamp");
    for (int i = 0; i < 6; i++) push(-2047 * pat[i], (i == 5) ? 1 : 0, "R7 negative clamp");
    drain();
    chk(e_val[wp-7] == 8191, "R7 model high clamp", e_val[wp-7], 8191);
    chk(e_val[wp-1] == -8192, "R7 model low clamp", e_val[wp-1], -8192);
  endtask

  task automatic t_hold();
    int v, c;
    push(777, 2, "R8 before hold");
    drain();
    v = int'(out_sample);
    c = int'(out_chan);
    idle(10);
    chk(int'(out_sample) == v, "R8 sample held", int'(out_sample), v);
    chk(int'(out_chan) == c, "R8 lane held", int'(out_chan), c);
    chk(out_valid == 1'b0, "R8 valid low", int'(out_valid), 0);
  endtask

  initial begin
    sk[1] = '0; sk[2] = '0; sk[3] = '0;
    for (int k = 0; k < 6; k++) hist[k] = 0;
    t_reset();
    t_reference_lane();
    t_ramp();
    t_switch();
    t_gaps();
    t_saturate();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule